// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns a 13-bit SDRAM mode word into a burst configuration: length, ordering, read latency and write mode. It then produces the column address of every beat of a read or write burst. A controller loads the mode word with a one-cycle load strobe. Each access is launched with a one-cycle start strobe, which carries the first column and a read/write flag. One clock after the start, the block presents the first beat. Each following clock presents the next column, with a valid flag and a final-beat flag, until the burst ends.

Beats follow either a sequential or an interleaved order inside a block of the programmed length, and the column bits above that block never change. In full-page mode the column runs across the whole row, wraps from the top column back to zero, and keeps going until a stop strobe arrives. The stop strobe can also end any shorter burst early. A fresh start can cut into a burst that is still running. When the single-write mode is set, every write is one beat long.

A mode word holding a reserved code is rejected as a whole: an error flag goes up and the previous configuration stays in force. The reset input is active low and asynchronous. Its release is expected to be synchronised to the clock upstream. All outputs come from registers, so there is no combinational path from any input to any output.

Top module: `sdram_burst_addr_gen`

## Requirements
- R1: The length field, mode bits 2..0, decodes code 000, 001, 010 or 011 to 1, 2, 4 or 8 beats. `cfg_len_log` then reads 0, 1, 2 or 3, its value being log2 of the length.
- R2: Length code 111 together with mode bit 3 at 0 selects a full-page burst, shown as `cfg_len_log` = 9 (COL_W). Code 111 with bit 3 at 1 is reserved, and so are codes 100, 101 and 110.
- R3: The latency field, mode bits 6..4, decodes 010 to `cfg_cas_lat` = 2 and 011 to 3. Every other value of the field is reserved.
- R4: A load whose length or latency code is reserved, or whose bits 12..10, 8 or 7 are not zero, sets `cfg_err` from the next cycle and leaves the whole configuration unchanged. A load that is fully legal clears `cfg_err` and applies the new configuration from the next cycle.
- R5: Mode bit 3 selects the ordering (0 sequential, 1 interleave), shown on `cfg_interleave`. Mode bit 9 selects single-beat writes, shown on `cfg_single_wr`.
- R6: The cycle after `start` is sampled high, `beat_valid` is 1 and `col_out` equals the sampled `start_col`. This first beat is beat 0.
- R7: In sequential order, for a burst of length BL, beat n carries a column whose low log2(BL) bits are (start + n) mod BL. The column bits above those stay equal to the start column's.
- R8: In interleave order, beat n carries a column whose low log2(BL) bits are the start column's low bits XOR n. The upper bits stay fixed.
- R9: `beat_last` is 1 only on the final beat of a burst of length 1, 2, 4 or 8. In the cycle after that beat, `beat_valid` is 0 unless a new start was sampled.
- R10: A full-page burst steps the column by one every cycle, wraps from 511 to 0, never raises `beat_last`, and runs until it is stopped or restarted.
- R11: When `stop` is sampled high during a valid beat and `start` is low, no further beat follows: `beat_valid` is 0 in the next cycle.
- R12: When `start` is sampled high during a running burst, the next cycle shows beat 0 of the new burst, even if `stop` is high in the same cycle.
- R13: When single-beat writes are selected, a write start (`start_wr` = 1) gives exactly one beat with `beat_last` = 1, whatever the programmed length. Reads keep the programmed length, and writes do too when the mode is clear.
- R14: After reset, `beat_valid`, `beat_last` and `cfg_err` are 0, `cfg_len_log` is 0, `cfg_interleave` and `cfg_single_wr` are 0, and `cfg_cas_lat` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the mode word |
| cfg_word | input | 13 | Mode word |
| start | input | 1 | Burst start strobe |
| start_wr | input | 1 | 1 when the starting burst is a write |
| start_col | input | COL_W | First column of the burst |
| stop | input | 1 | Ends the running burst after the current beat |
| col_out | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | The current beat is the final one |
| cfg_err | output | 1 | The last load held a reserved code |
| cfg_len_log | output | 5 | log2 of the burst length, COL_W for full page |
| cfg_cas_lat | output | 2 | Decoded read latency |
| cfg_interleave | output | 1 | Interleaved ordering selected |
| cfg_single_wr | output | 1 | Single-beat writes selected |

## Verification
The bench builds the block with its default COL_W of 9, so one row is 512 columns. This is small enough to start a burst from every column of the row for each of the four fixed lengths in both orderings, which covers every carry and XOR pattern of the low bits. The bench also sweeps all 128 values of the length, ordering and latency bits under both write modes, following the expected configuration with its own model of which loads are rejected. The 9-bit column makes a full-page wrap past 511 reachable within a few hundred cycles, together with the stop and restart cases.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int MODE_W    = 13;
  localparam int LEN_LOG_W = 5;

  // mode word field positions (decoded by the neighbouring controller too)
  localparam int BL_LSB = 0;
  localparam int BT_BIT = 3;
  localparam int CL_LSB = 4;
  localparam int WM_BIT = 9;

  typedef struct packed {
    logic [LEN_LOG_W-1:0] len_log;
    logic                 interleave;
    logic                 single_wr;
    logic [1:0]           cas_lat;
  } burst_cfg_t;
endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
  import burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output burst_cfg_t        cfg,
  output logic              err
);
  logic [2:0] bl_code;
  logic [2:0] cl_code;
  logic       bl_ok;
  logic       cl_ok;
  logic       pad_ok;
  burst_cfg_t cand;
  burst_cfg_t cfg_nx;
  logic       err_nx;

  always_comb begin
    bl_code = word[BL_LSB +: 3];
    cl_code = word[CL_LSB +: 3];
    pad_ok  = (word[12:10] == 3'b000) && (word[8:7] == 2'b00);
    cand.interleave = word[BT_BIT];
    cand.single_wr  = word[WM_BIT];
    bl_ok = 1'b1;
    cand.len_log = '0;
    case (bl_code)
      3'b000: cand.len_log = LEN_LOG_W'(0);
      3'b001: cand.len_log = LEN_LOG_W'(1);
      3'b010: cand.len_log = LEN_LOG_W'(2);
      3'b011: cand.len_log = LEN_LOG_W'(3);
      3'b111: begin
        cand.len_log = LEN_LOG_W'(COL_W);
        bl_ok        = ~word[BT_BIT];
      end
      default: bl_ok = 1'b0;
    endcase
    cl_ok = 1'b1;
    case (cl_code)
      3'b010:  cand.cas_lat = 2'd2;
      3'b011:  cand.cas_lat = 2'd3;
      default: begin
        cand.cas_lat = 2'd2;
        cl_ok        = 1'b0;
      end
    endcase
    if (bl_ok && cl_ok && pad_ok) begin
      cfg_nx = cand;
      err_nx = 1'b0;
    end else begin
      cfg_nx = cfg;
      err_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.len_log    <= '0;
      cfg.interleave <= 1'b0;
      cfg.single_wr  <= 1'b0;
      cfg.cas_lat    <= 2'd2;
      err            <= 1'b0;
    end else if (load) begin
      cfg <= cfg_nx;
      err <= err_nx;
    end
  end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int COL_W     = 9,
  parameter int LEN_LOG_W = 5
) (
  input  logic [COL_W-1:0]     base,
  input  logic [COL_W-1:0]     cnt,
  input  logic [LEN_LOG_W-1:0] len_log,
  input  logic                 interleave,
  output logic [COL_W-1:0]     mask,
  output logic [COL_W-1:0]     col
);
  logic [COL_W-1:0] low;

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask[i] = (LEN_LOG_W'(i) < len_log);
  end

  always_comb begin
    low = interleave ? (base ^ cnt) : (base + cnt);
    col = (base & ~mask) | (low & mask);
  end
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq #(
  parameter int COL_W     = 9,
  parameter int LEN_LOG_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_wr,
  input  logic [COL_W-1:0]     start_col,
  input  logic                 stop,
  input  logic [LEN_LOG_W-1:0] cfg_len_log,
  input  logic                 cfg_interleave,
  input  logic                 cfg_single_wr,
  input  logic [COL_W-1:0]     mask,
  output logic                 valid,
  output logic                 last,
  output logic [COL_W-1:0]     base,
  output logic [COL_W-1:0]     cnt,
  output logic [LEN_LOG_W-1:0] len_log,
  output logic                 interleave
);
  localparam logic [LEN_LOG_W-1:0] FULL_LOG = LEN_LOG_W'(COL_W);

  logic                 full;
  logic                 en;
  logic                 valid_nx;
  logic [COL_W-1:0]     base_nx;
  logic [COL_W-1:0]     cnt_nx;
  logic [LEN_LOG_W-1:0] len_nx;
  logic                 il_nx;

  assign full = (len_log == FULL_LOG);
  assign last = valid && !full && (cnt == mask);
  assign en   = start || valid;

  always_comb begin
    valid_nx = valid;
    base_nx  = base;
    cnt_nx   = cnt;
    len_nx   = len_log;
    il_nx    = interleave;
    if (start) begin
      valid_nx = 1'b1;
      base_nx  = start_col;
      cnt_nx   = '0;
      len_nx   = (start_wr && cfg_single_wr) ? '0 : cfg_len_log;
      il_nx    = cfg_interleave;
    end else if (valid) begin
      if (stop || last) valid_nx = 1'b0;
      else              cnt_nx   = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid      <= 1'b0;
      base       <= '0;
      cnt        <= '0;
      len_log    <= '0;
      interleave <= 1'b0;
    end else if (en) begin
      valid      <= valid_nx;
      base       <= base_nx;
      cnt        <= cnt_nx;
      len_log    <= len_nx;
      interleave <= il_nx;
    end
  end
endmodule

// File: rtl/sdram_burst_addr_gen.sv
module sdram_burst_addr_gen
  import burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic [MODE_W-1:0]    cfg_word,
  input  logic                 start,
  input  logic                 start_wr,
  input  logic [COL_W-1:0]     start_col,
  input  logic                 stop,
  output logic [COL_W-1:0]     col_out,
  output logic                 beat_valid,
  output logic                 beat_last,
  output logic                 cfg_err,
  output logic [LEN_LOG_W-1:0] cfg_len_log,
  output logic [1:0]           cfg_cas_lat,
  output logic                 cfg_interleave,
  output logic                 cfg_single_wr
);
  burst_cfg_t           cfg;
  logic [COL_W-1:0]     mask;
  logic [COL_W-1:0]     base;
  logic [COL_W-1:0]     cnt;
  logic [LEN_LOG_W-1:0] run_len;
  logic                 run_il;

  burst_mode_decode #(.COL_W(COL_W)) u_dec (
    .clk  (clk),
    .rst_n(rst_n),
    .load (cfg_load),
    .word (cfg_word),
    .cfg  (cfg),
    .err  (cfg_err)
  );

  burst_beat_seq #(.COL_W(COL_W), .LEN_LOG_W(LEN_LOG_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_wr      (start_wr),
    .start_col     (start_col),
    .stop          (stop),
    .cfg_len_log   (cfg.len_log),
    .cfg_interleave(cfg.interleave),
    .cfg_single_wr (cfg.single_wr),
    .mask          (mask),
    .valid         (beat_valid),
    .last          (beat_last),
    .base          (base),
    .cnt           (cnt),
    .len_log       (run_len),
    .interleave    (run_il)
  );

  burst_col_map #(.COL_W(COL_W), .LEN_LOG_W(LEN_LOG_W)) u_map (
    .base      (base),
    .cnt       (cnt),
    .len_log   (run_len),
    .interleave(run_il),
    .mask      (mask),
    .col       (col_out)
  );

  assign cfg_len_log    = cfg.len_log;
  assign cfg_cas_lat    = cfg.cas_lat;
  assign cfg_interleave = cfg.interleave;
  assign cfg_single_wr  = cfg.single_wr;
endmodule

// File: rtl/burst_addr_checker.sv
module burst_addr_checker
  import burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic [COL_W-1:0]     start_col,
  input logic                 stop,
  input logic [COL_W-1:0]     col_out,
  input logic                 beat_valid,
  input logic                 beat_last,
  input logic                 cfg_err,
  input logic [LEN_LOG_W-1:0] cfg_len_log,
  input logic [1:0]           cfg_cas_lat,
  input logic                 cfg_interleave,
  input logic                 cfg_single_wr
);
  assert_first_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_valid && col_out == $past(start_col)));

  assert_stop_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && stop && !start) |=> !beat_valid);

  assert_last_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_last && !start) |=> !beat_valid);

  assert_last_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  assert_keeps_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last && !stop && !start) |=> beat_valid);

  assert_reject_keeps_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> ($stable(cfg_len_log) && $stable(cfg_cas_lat) &&
                        $stable(cfg_interleave) && $stable(cfg_single_wr)));

  assert_latency_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cas_lat == 2'd2) || (cfg_cas_lat == 2'd3));
endmodule

bind sdram_burst_addr_gen burst_addr_checker #(.COL_W(COL_W)) u_chk (.*);

// File: tb/tb_sdram_burst_addr_gen.sv
module tb_sdram_burst_addr_gen;
  import burst_pkg::*;
  localparam int COL_W      = 9;
  localparam int CLK_PERIOD = 10;
  localparam int ROW        = 1 << COL_W;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 cfg_load;
  logic [MODE_W-1:0]    cfg_word;
  logic                 start;
  logic                 start_wr;
  logic [COL_W-1:0]     start_col;
  logic                 stop;
  logic [COL_W-1:0]     col_out;
  logic                 beat_valid;
  logic                 beat_last;
  logic                 cfg_err;
  logic [LEN_LOG_W-1:0] cfg_len_log;
  logic [1:0]           cfg_cas_lat;
  logic                 cfg_interleave;
  logic                 cfg_single_wr;

  int n_tests = 0;
  int n_fail  = 0;
  int m_len = 0, m_cas = 2;
  bit m_il = 0, m_sw = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_addr_gen #(.COL_W(COL_W)) dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_cfg(logic [MODE_W-1:0] w);
    bit    ok;
    string lt;
    @(negedge clk);
    cfg_load = 1'b1;
    cfg_word = w;
    @(negedge clk);
    cfg_load = 1'b0;
    ok = (w[2:0] <= 3'd3 || (w[2:0] == 3'd7 && !w[3])) &&
         (w[6:4] == 3'd2 || w[6:4] == 3'd3) &&
         (w[12:10] == 3'd0) && (w[8:7] == 2'd0);
    if (ok) begin
      m_len = (w[2:0] == 3'd7) ? COL_W : int'(w[2:0]);
      m_cas = int'(w[6:4]);
      m_il  = w[3];
      m_sw  = w[9];
    end
    lt = (w[2:0] >= 3'd4) ? "R2" : "R1";
    chk("R4", "cfg_err", int'(cfg_err), int'(!ok));
    chk(lt, "cfg_len_log", int'(cfg_len_log), m_len);
    chk("R3", "cfg_cas_lat", int'(cfg_cas_lat), m_cas);
    chk("R5", "cfg_interleave", int'(cfg_interleave), int'(m_il));
    chk("R5", "cfg_single_wr", int'(cfg_single_wr), int'(m_sw));
  endtask

  function automatic int exp_col(int col, int n, int l, bit il);
    int mask = (1 << l) - 1;
    int low  = il ? (col ^ n) : (col + n);
    return ((col & ~mask) | (low & mask)) & (ROW - 1);
  endfunction

  // launches a burst and checks `beats` beats; a full burst is left running
  task automatic run_burst(string req, int col, bit wr, int beats, int l, bit il, bit full);
    @(negedge clk);
    start     = 1'b1;
    start_wr  = wr;
    start_col = COL_W'(col);
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < beats; n++) begin
      chk(n == 0 ? "R6" : req, "beat_valid", int'(beat_valid), 1);
      chk(req, "col_out", int'(col_out), exp_col(col, n, l, il));
      chk(full ? "R10" : "R9", "beat_last", int'(beat_last), int'(!full && n == beats - 1));
      @(negedge clk);
    end
    if (!full) chk("R9", "beat_valid after final", int'(beat_valid), 0);
  endtask

  function automatic logic [MODE_W-1:0] mw(bit a9, int cl, bit bt, int bl);
    return {3'b000, a9, 2'b00, 3'(cl), bt, 3'(bl)};
  endfunction

  initial begin
    #(150000 * CLK_PERIOD);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_word = '0; start = 1'b0;
    start_wr = 1'b0; start_col = '0; stop = 1'b0;
    #(3 * CLK_PERIOD + 1);
    chk("R14", "beat_valid", int'(beat_valid), 0);
    chk("R14", "beat_last", int'(beat_last), 0);
    chk("R14", "cfg_err", int'(cfg_err), 0);
    chk("R14", "cfg_len_log", int'(cfg_len_log), 0);
    chk("R14", "cfg_cas_lat", int'(cfg_cas_lat), 2);
    chk("R14", "cfg_interleave", int'(cfg_interleave), 0);
    chk("R14", "cfg_single_wr", int'(cfg_single_wr), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5: all length, ordering and latency codes, both write modes
    for (int a9 = 0; a9 < 2; a9++)
      for (int w = 0; w < 128; w++)
        load_cfg({3'b000, 1'(a9), 2'b00, 7'(w)});

    // R4: nonzero pad bits are rejected and the configuration is kept
    load_cfg(mw(0, 3, 1, 2));
    load_cfg(mw(0, 3, 1, 2) | 13'h0400);
    load_cfg(mw(0, 3, 1, 2) | 13'h0080);
    load_cfg(mw(0, 2, 1, 5));
    run_burst("R4", 13, 0, 4, 2, 1, 0);

    // R7 R8: every start column for each fixed length and ordering
    for (int l = 0; l < 4; l++)
      for (int il = 0; il < 2; il++) begin
        load_cfg(mw(0, 2, 1'(il), l));
        for (int c = 0; c < ROW; c++)
          run_burst(il ? "R8" : "R7", c, 1'(c & 1), 1 << l, l, 1'(il), 0);
      end

    // R10 R11: full page wraps past the top column, then is stopped
    load_cfg(mw(0, 3, 0, 7));
    run_burst("R10", 500, 0, 30, COL_W, 0, 1);
    stop = 1'b1;
    chk("R11", "beat_valid at stop", int'(beat_valid), 1);
    chk("R10", "col_out after wrap", int'(col_out), 18);
    @(negedge clk);
    stop = 1'b0;
    chk("R11", "beat_valid after stop", int'(beat_valid), 0);
    run_burst("R10", 5, 1, ROW + 3, COL_W, 0, 1);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R11", "beat_valid after long stop", int'(beat_valid), 0);

    // R11: early stop of a fixed-length burst
    load_cfg(mw(0, 2, 0, 3));
    @(negedge clk); start = 1'b1; start_wr = 1'b0; start_col = 9'd8;
    @(negedge clk); start = 1'b0;
    chk("R11", "col beat0", int'(col_out), 8);
    @(negedge clk);
    chk("R11", "col beat1", int'(col_out), 9);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R11", "beat_valid after early stop", int'(beat_valid), 0);
    chk("R11", "beat_last after early stop", int'(beat_last), 0);

    // R12: restart with stop high in the same cycle
    @(negedge clk); start = 1'b1; start_col = 9'd16;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R12", "col before restart", int'(col_out), 18);
    start = 1'b1; stop = 1'b1; start_col = 9'd100;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    for (int n = 0; n < 8; n++) begin
      chk("R12", "beat_valid", int'(beat_valid), 1);
      chk("R12", "col_out", int'(col_out), exp_col(100, n, 3, 0));
      chk("R12", "beat_last", int'(beat_last), int'(n == 7));
      @(negedge clk);
    end
    chk("R12", "beat_valid after restarted burst", int'(beat_valid), 0);

    // R13: single-beat writes
    load_cfg(mw(1, 2, 0, 3));
    run_burst("R13", 37, 1, 1, 0, 0, 0);
    run_burst("R13", 37, 0, 8, 3, 0, 0);
    load_cfg(mw(0, 2, 0, 3));
    run_burst("R13", 37, 1, 8, 3, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule